// File: doc/BRIEF.md
# Slave Frame-Sync Phase Tracker

This block keeps an internal frame-timing counter, clocked by the master oversampling clock, in step with a word-select (frame) clock that arrives from outside. The master clock runs at 256, 384 or 512 times the frame rate, chosen by a two-bit ratio select. After the system reset is released, the first rising edge of the frame clock fixes the counter phase. From then on, every rising frame edge is compared with the boundary the counter expects. An edge that lands close enough to that boundary leaves the counter alone. An edge that lands further away snaps the counter onto the new edge and reports the event.

The output data-valid flag stays low for a fixed number of frames after the first alignment, which covers the start-up delay of the data path. It also stays low for a shorter number of frames after any later realignment. Downstream logic uses the frame phase to schedule per-frame work and uses the data-valid flag to gate the samples it emits.

Top module: `frame_sync_tracker`

## Requirements
- R1: While `sys_rst` is high, at the next clock edge `frame_phase` becomes 0 and `resync` and `data_valid` become 0. The ratio select is captured only while `sys_rst` is high.
- R2: After reset release, the first frame-clock rising edge aligns the counter. In the cycle where the one-cycle `resync` pulse is high, `frame_phase` reads 2. Phase 0 is the master-clock edge that first sampled the frame clock high, and the two-stage input synchronizer accounts for the difference.
- R3: The frame length L is 256 for ratio code 00, 384 for 01, 512 for 10 and 256 for 11. The counter steps by one per cycle and wraps from L-1 to 0.
- R4: A rising frame edge whose phase error, taken modulo L, lies within ±L/16 inclusive (16, 24 or 32 cycles) causes no change. There is no `resync` pulse and the counter keeps its sequence. This holds for errors on both sides of the wrap.
- R5: A rising frame edge whose error is larger than L/16 realigns the counter. `resync` pulses for one cycle, with `frame_phase` equal to 2 in that cycle.
- R6: After the first alignment, `data_valid` rises on the counter wrap that ends frame SETTLE_FRAMES+VALID_FRAMES. With default parameters that is 2+516 frames. The flag is low while no alignment exists.
- R7: A realignment drops `data_valid` in the cycle of the `resync` pulse. The flag returns only after the larger of BLANK_FRAMES (default 4) and the frames still pending further counter wraps.
- R8: A change of `ratio_sel` while `sys_rst` is low has no effect on the frame length.
- R9: `resync` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xti_clk | input | 1 | Master oversampling clock |
| sys_rst | input | 1 | System reset state, synchronous, active high |
| lrclk | input | 1 | External frame clock, asynchronous to nothing but not sampled cleanly |
| ratio_sel | input | 2 | Master-clock-to-frame ratio code, captured during reset |
| frame_phase | output | PH_W | Internal frame phase counter (9 bits by default) |
| resync | output | 1 | One-cycle pulse at each alignment or realignment |
| data_valid | output | 1 | High when output data may be used |

## Verification
A phase counter that is out by a few cycles does not show up at the ports until the next frame edge. At that point it either causes a spurious `resync` pulse or fails to raise one where the bench expects it. Because of this, every offset vector is checked over several whole frames after the disturbed edge. A wrong frame length shows within one frame as the wrong maximum phase. A wrong hold count shows only on the exact cycle `data_valid` changes, so both the cycle before and the cycle after that change are sampled. A hold timer that ignores the remaining count would show only after a realignment during start-up.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  typedef enum logic {
    TRK_HUNT = 1'b0,
    TRK_LOCK = 1'b1
  } trk_state_e;

  // Frame length for a ratio code; code 3 falls back to the shortest length.
  function automatic int unsigned ratio_len(input logic [1:0] sel,
                                            input int unsigned len_a,
                                            input int unsigned len_b,
                                            input int unsigned len_c);
    case (sel)
      2'b00:   return len_a;
      2'b01:   return len_b;
      2'b10:   return len_c;
      default: return len_a;
    endcase
  endfunction

endpackage

// File: rtl/fsync_edge.sv
module fsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/fsync_window.sv
module fsync_window #(
  parameter int PH_W = 9,
  parameter int LAT  = 2
) (
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W:0]   len,
  output logic            mismatch
);
  localparam int LEN_W = PH_W + 1;
  localparam logic [LEN_W:0] ALIGNED = (LEN_W+1)'(LAT - 1);

  logic [LEN_W:0]   raw;
  logic [LEN_W:0]   err;
  logic [LEN_W:0]   win;
  logic [LEN_W:0]   len_x;

  always_comb begin
    len_x = {1'b0, len};
    win   = len_x >> 4;
    raw   = {2'b00, phase} + len_x - ALIGNED;
    err   = (raw >= len_x) ? (raw - len_x) : raw;
    mismatch = !((err <= win) || (err >= (len_x - win)));
  end
endmodule

// File: rtl/fsync_hold.sv
module fsync_hold #(
  parameter int INIT_FRAMES  = 518,
  parameter int BLANK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic first_lock,
  input  logic realign,
  input  logic tick,
  output logic valid
);
  localparam int HOLD_MAX = (INIT_FRAMES > BLANK_FRAMES) ? INIT_FRAMES : BLANK_FRAMES;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
  localparam logic [HOLD_W-1:0] INIT_V  = HOLD_W'(INIT_FRAMES);
  localparam logic [HOLD_W-1:0] BLANK_V = HOLD_W'(BLANK_FRAMES);
  localparam logic [HOLD_W-1:0] ONE_V   = HOLD_W'(1);

  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      valid  <= 1'b0;
    end else if (first_lock) begin
      hold_q <= INIT_V;
      valid  <= 1'b0;
    end else if (realign) begin
      hold_q <= (hold_q > BLANK_V) ? hold_q : BLANK_V;
      valid  <= 1'b0;
    end else if (tick && hold_q != '0) begin
      hold_q <= hold_q - ONE_V;
      valid  <= (hold_q == ONE_V);
    end
  end
endmodule

// File: rtl/frame_sync_tracker.sv
module frame_sync_tracker #(
  parameter int LEN_A         = 256,
  parameter int LEN_B         = 384,
  parameter int LEN_C         = 512,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_FRAMES = 2,
  parameter int VALID_FRAMES  = 516,
  parameter int BLANK_FRAMES  = 4,
  parameter int PH_W          = $clog2(LEN_C)
) (
  input  logic            xti_clk,
  input  logic            sys_rst,
  input  logic            lrclk,
  input  logic [1:0]      ratio_sel,
  output logic [PH_W-1:0] frame_phase,
  output logic            resync,
  output logic            data_valid
);
  import fsync_pkg::*;

  localparam int LEN_W = PH_W + 1;
  localparam int LAT   = SYNC_STAGES;
  localparam logic [PH_W-1:0]  LAT_PH  = PH_W'(LAT);
  localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

  trk_state_e       state_q;
  logic [LEN_W-1:0] len_q;
  logic             rise;
  logic             mismatch;
  logic             locked;
  logic             first_lock;
  logic             realign;
  logic             at_wrap;
  logic             tick;

  fsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (xti_clk),
    .rst      (sys_rst),
    .async_in (lrclk),
    .rise     (rise)
  );

  fsync_window #(.PH_W(PH_W), .LAT(LAT)) u_window (
    .phase    (frame_phase),
    .len      (len_q),
    .mismatch (mismatch)
  );

  assign locked     = (state_q == TRK_LOCK);
  assign first_lock = !locked && rise;
  assign realign    = locked && rise && mismatch;
  assign at_wrap    = ({1'b0, frame_phase} == (len_q - ONE_LEN));
  assign tick       = locked && !realign && at_wrap;

  always_ff @(posedge xti_clk) begin
    if (sys_rst) begin
      state_q     <= TRK_HUNT;
      len_q       <= LEN_W'(ratio_len(ratio_sel, LEN_A, LEN_B, LEN_C));
      frame_phase <= '0;
      resync      <= 1'b0;
    end else begin
      resync <= first_lock || realign;
      if (first_lock) begin
        state_q     <= TRK_LOCK;
        frame_phase <= LAT_PH;
      end else if (realign) begin
        frame_phase <= LAT_PH;
      end else if (locked) begin
        frame_phase <= at_wrap ? '0 : frame_phase + 1'b1;
      end
    end
  end

  fsync_hold #(
    .INIT_FRAMES  (SETTLE_FRAMES + VALID_FRAMES),
    .BLANK_FRAMES (BLANK_FRAMES)
  ) u_hold (
    .clk        (xti_clk),
    .rst        (sys_rst),
    .first_lock (first_lock),
    .realign    (realign),
    .tick       (tick),
    .valid      (data_valid)
  );
endmodule

// File: rtl/frame_sync_tracker_chk.sv
module frame_sync_tracker_chk #(
  parameter int PH_W = 9,
  parameter int LAT  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [PH_W-1:0] phase,
  input logic            resync,
  input logic            valid,
  input logic [PH_W:0]   len_q,
  input logic            locked
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (phase == '0 && !resync && !valid));

  assert_align_phase_R2: assert property (@(posedge clk) disable iff (rst)
    resync |-> (phase == PH_W'(LAT)));

  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, phase} < len_q));

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked) && !$past(rst) && !resync) |->
      ({1'b0, phase} == (({1'b0, $past(phase)} == len_q - 1'b1) ? '0
                         : {1'b0, $past(phase)} + 1'b1)));

  assert_hunt_invalid_R6: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !valid);

  assert_resync_blank_R7: assert property (@(posedge clk) disable iff (rst)
    resync |-> !valid);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    resync |=> !resync);
endmodule

bind frame_sync_tracker frame_sync_tracker_chk #(.PH_W(PH_W), .LAT(SYNC_STAGES)) u_chk (
  .clk    (xti_clk),
  .rst    (sys_rst),
  .phase  (frame_phase),
  .resync (resync),
  .valid  (data_valid),
  .len_q  (len_q),
  .locked (locked)
);

// File: tb/frame_sync_tracker_bench.sv
module frame_sync_tracker_bench;
  localparam int PH_W   = 9;
  localparam int SETTLE = 2;
  localparam int VALID  = 6;
  localparam int BLANK  = 4;
  localparam int VEC_N  = 10;
  // {ratio code, edge offset in cycles, expected resync pulses}
  localparam int VEC [VEC_N][3] = '{
    '{0,   0, 0}, '{0,  16, 0}, '{0, -16, 0}, '{0,  17, 1}, '{0, -17, 1},
    '{1,  24, 0}, '{1,  25, 1}, '{2, -32, 0}, '{2, -33, 1}, '{3,  17, 1}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            lrclk = 1'b0;
  logic [1:0]      ratio_sel = 2'b00;
  logic [PH_W-1:0] frame_phase;
  logic            resync;
  logic            data_valid;

  int n_chk = 0, n_err = 0, cyc = 0;
  int gen_len = 256, pend = 0, sh = 0;
  bit gen_on = 1'b0;
  int rs_count = 0, last_rs_cyc = 0, last_rs_phase = 0, last_rs_valid = 0, max_ph = 0;

  always #4 clk = ~clk;

  frame_sync_tracker #(
    .SETTLE_FRAMES (SETTLE),
    .VALID_FRAMES  (VALID),
    .BLANK_FRAMES  (BLANK)
  ) u_frame_sync_tracker (
    .xti_clk     (clk),
    .sys_rst     (rst),
    .lrclk       (lrclk),
    .ratio_sel   (ratio_sel),
    .frame_phase (frame_phase),
    .resync      (resync),
    .data_valid  (data_valid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    if (!gen_on) begin
      lrclk = 1'b0;
      @(negedge clk);
    end else begin
      lrclk = 1'b1;
      repeat (gen_len / 2) @(negedge clk);
      lrclk = 1'b0;
      sh = pend;
      pend = 0;
      repeat (gen_len / 2 + sh) @(negedge clk);
    end
  end

  always @(negedge clk) begin
    if (resync) begin
      rs_count++;
      last_rs_cyc   = cyc;
      last_rs_phase = int'(frame_phase);
      last_rs_valid = int'(data_valid);
    end
    if (int'(frame_phase) > max_ph) max_ph = int'(frame_phase);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic restart(input logic [1:0] sel, input int len);
    step(1);
    rst = 1'b1;
    gen_on = 1'b0;
    ratio_sel = sel;
    gen_len = len;
    step(len + 4);
    check(frame_phase == '0 && !resync && !data_valid, "R1 reset state",
          int'(frame_phase) + int'(resync) + int'(data_valid), 0);
    rst = 1'b0;
    gen_on = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int rs0;
    int len;
    int target;
    // Offset vectors: R4 small errors kept, R5 large errors realigned, R9 single pulse
    for (int v = 0; v < VEC_N; v++) begin
      len = (VEC[v][0] == 1) ? 384 : (VEC[v][0] == 2) ? 512 : 256;
      restart(VEC[v][0][1:0], len);
      step(4 * len);
      rs0 = rs_count;
      pend = VEC[v][1];
      step(4 * len);
      check(rs_count - rs0 == VEC[v][2],
            (VEC[v][2] != 0) ? "R5/R9 realign pulses" : "R4 window kept",
            rs_count - rs0, VEC[v][2]);
      if (VEC[v][2] != 0)
        check(last_rs_phase == 2, "R5 phase after realign", last_rs_phase, 2);
    end

    // R2: initial alignment and R6: start-up valid timing
    restart(2'b00, 256);
    rs0 = rs_count;
    step(300);
    check(rs_count - rs0 == 1, "R2 single lock pulse", rs_count - rs0, 1);
    check(last_rs_phase == 2, "R2 lock phase", last_rs_phase, 2);
    target = last_rs_cyc + (SETTLE + VALID) * 256 - 3;
    wait_cyc(target);
    check(!data_valid, "R6 valid before hold end", int'(data_valid), 0);
    @(negedge clk);
    check(data_valid, "R6 valid at hold end", int'(data_valid), 1);

    // R7: realign blanks for BLANK frames
    step(2 * 256);
    rs0 = rs_count;
    pend = 40;
    step(3 * 256);
    check(rs_count - rs0 == 1, "R7 realign pulse", rs_count - rs0, 1);
    check(last_rs_valid == 0, "R7 valid low at pulse", last_rs_valid, 0);
    target = last_rs_cyc + BLANK * 256 - 3;
    wait_cyc(target);
    check(!data_valid, "R7 valid still blanked", int'(data_valid), 0);
    @(negedge clk);
    check(data_valid, "R7 valid restored", int'(data_valid), 1);

    // R8: ratio change while running is ignored; R3 frame length 256
    step(1);
    ratio_sel = 2'b10;
    rs0 = rs_count;
    max_ph = 0;
    step(4 * 256);
    check(rs_count == rs0, "R8 no resync after ratio change", rs_count - rs0, 0);
    check(max_ph == 255, "R8 frame length kept", max_ph, 255);

    // R3: frame length for code 01 and code 11
    restart(2'b01, 384);
    step(2 * 384);
    max_ph = 0;
    step(2 * 384);
    check(max_ph == 383, "R3 length code 01", max_ph, 383);
    restart(2'b11, 256);
    step(2 * 256);
    max_ph = 0;
    step(2 * 256);
    check(max_ph == 255, "R3 length code 11", max_ph, 255);

    // R1: reset in mid-run clears outputs
    rst = 1'b1;
    step(2);
    check(frame_phase == '0 && !resync && !data_valid, "R1 mid-run reset",
          int'(frame_phase) + int'(data_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule